// File: doc/BRIEF.md
# Converter Control Bus Target

This block is the two-wire serial bus target that sits in front of a sampling converter's sequencing logic. It watches the clock and data lines of a standard I2C bus, filters both through synchronizer stages into the system clock domain, and decodes write transactions aimed at either its own 7-bit address or a shared broadcast address. A bus master uses it to restart a conversion and, optionally, to switch the output rate between a slow (30 Hz) and a fast (60 Hz) mode.

The target only acknowledges its address once the converter reports that it is idle. An acknowledged write may carry one configuration byte. The STOP that closes an acknowledged write loads the configuration (only if a byte was received) and fires a single-cycle conversion-start strobe, which also tells the converter to throw away any result nobody has read. Because several targets can share the broadcast address, one short transaction restarts all of them on the same STOP. Read-back of results and clock stretching are not part of this block.

Top module: `cnv_ctl_i2c_target`

## Requirements
- R1: A write to the own address (default 7'b0010100, address byte sent MSB first, last bit 0 = write) while `conv_busy_i` is low is acknowledged: `sda_drive_low_o` goes high after the SCL falling edge that ends the 8th bit and drops after the falling edge that ends the 9th.
- R2: A write to the broadcast address (default 7'b1110111) while idle is acknowledged in the same way as R1.
- R3: If `conv_busy_i` is high when the address byte completes, the address is not acknowledged, and the STOP that follows neither pulses `conv_start_o` nor changes `rate_slow_o`.
- R4: The data byte that follows an acknowledged address is acknowledged; its bit 0 picks the rate (1 = slow, 30 Hz, `rate_slow_o`=1; 0 = fast, 60 Hz), and its other seven bits have no effect.
- R5: A STOP after an acknowledged address and a full data byte updates `rate_slow_o` and pulses `conv_start_o` once, discarding any unread earlier result.
- R6: A STOP after an acknowledged address but before any complete data byte pulses `conv_start_o` once and leaves `rate_slow_o` unchanged.
- R7: An address that matches neither address, or any read request (last address bit 1), is not acknowledged; the following STOP neither pulses `conv_start_o` nor changes `rate_slow_o`.
- R8: A repeated START in the middle of an address byte discards the bits received so far, and address reception starts over.
- R9: `conv_start_o` is high for exactly one system clock and only two clocks after a detected STOP.
- R10: After reset `sda_drive_low_o` and `conv_start_o` are low and `rate_slow_o` equals 0 (fast mode).
- R11: Bytes after the first data byte are not acknowledged; the closing STOP still commits the first byte and pulses `conv_start_o` once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_drive_low_o | output | 1 | Enables the open-drain pull-down on the data line (acknowledge) |
| conv_busy_i | input | 1 | High while the converter is running a conversion |
| conv_start_o | output | 1 | One-clock strobe: discard old result and start a conversion |
| rate_slow_o | output | 1 | Rate mode: 1 = 30 Hz, 0 = 60 Hz |

## Verification
On every clock the assertions check that the acknowledge drive only switches on right after an SCL falling edge, that an address acknowledge never follows a busy converter, that the start strobe is one cycle wide and always trails a STOP by two clocks, and that the rate never moves without a start strobe. Whether the right addresses are accepted, whether bit 0 alone sets the rate, whether an aborted write keeps the old configuration, and how a repeated START or an extra byte is handled can only be seen in the bench's bus transactions, which compare acknowledge bits, strobe counts and the rate output against values worked out from the requirements.

// File: rtl/cnv_ctl_pkg.sv
package cnv_ctl_pkg;

   // Transaction phase of the bus target
   typedef enum logic [2:0] {
      PH_IDLE     = 3'd0,
      PH_ADDR     = 3'd1,
      PH_ADDR_ACK = 3'd2,
      PH_DATA     = 3'd3,
      PH_DATA_ACK = 3'd4,
      PH_SKIP     = 3'd5
   } phase_t;

   localparam int BYTE_BITS = 8;
   localparam int ADDR_BITS = 7;

endpackage

// File: rtl/cnv_line_sync.sv
module cnv_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   localparam int LINES = 2;

   if (STAGES < 2) begin : g_bad_stages
      $error("cnv_line_sync: STAGES must be at least 2");
   end

   logic [LINES-1:0] raw;
   logic [LINES-1:0] synced;
   logic [LINES-1:0] prev;

   assign raw = {sda_raw, scl_raw};

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= synced;
   end

   // index 0 = clock line, index 1 = data line
   assign sda_s     = synced[1];
   assign scl_rise  =  synced[0] & ~prev[0];
   assign scl_fall  = ~synced[0] &  prev[0];
   assign start_det =  synced[0] &  prev[0] &  prev[1] & ~synced[1];
   assign stop_det  =  synced[0] &  prev[0] & ~prev[1] &  synced[1];

endmodule

// File: rtl/cnv_bus_engine.sv
module cnv_bus_engine
   import cnv_ctl_pkg::*;
#(
   parameter logic [6:0] OWN_ADDR  = 7'b0010100,
   parameter logic [6:0] SYNC_ADDR = 7'b1110111,
   parameter bit         GLOBAL_EN = 1'b1,
   parameter int         RATE_BIT  = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sda_s,
   input  logic scl_rise,
   input  logic scl_fall,
   input  logic start_det,
   input  logic stop_det,
   input  logic conv_busy_i,
   output logic ack_drive_o,
   output logic commit_stb_o,
   output logic commit_load_o,
   output logic rate_new_o
);

   localparam int CNT_W = $clog2(BYTE_BITS + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

   if (RATE_BIT < 0 || RATE_BIT >= BYTE_BITS) begin : g_bad_rate_bit
      $error("cnv_bus_engine: RATE_BIT out of byte range");
   end
   if (GLOBAL_EN && (OWN_ADDR == SYNC_ADDR)) begin : g_bad_addr
      $error("cnv_bus_engine: own and broadcast address must differ");
   end

   phase_t               phase;
   logic [BYTE_BITS-1:0] shreg;
   logic [CNT_W-1:0]     bitcnt;
   logic                 armed;
   logic                 got_byte;
   logic                 pend_rate;
   logic                 stb_q;
   logic                 load_q;
   logic                 addr_hit;
   logic                 byte_done;

   // Address compare: broadcast match is a build option
   if (GLOBAL_EN) begin : g_match_both
      assign addr_hit = (shreg[7:1] == OWN_ADDR) || (shreg[7:1] == SYNC_ADDR);
   end else begin : g_match_own
      assign addr_hit = (shreg[7:1] == OWN_ADDR);
   end

   assign byte_done = scl_fall && (bitcnt == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         shreg     <= '0;
         bitcnt    <= '0;
         armed     <= 1'b0;
         got_byte  <= 1'b0;
         pend_rate <= 1'b0;
         stb_q     <= 1'b0;
         load_q    <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         if (stop_det) begin
            stb_q    <= armed;
            load_q   <= got_byte;
            phase    <= PH_IDLE;
            armed    <= 1'b0;
            got_byte <= 1'b0;
            bitcnt   <= '0;
         end else if (start_det) begin
            phase    <= PH_ADDR;
            bitcnt   <= '0;
            armed    <= 1'b0;
            got_byte <= 1'b0;
         end else begin
            case (phase)
               PH_ADDR: begin
                  if (scl_rise && bitcnt < LAST_BIT) begin
                     shreg  <= {shreg[BYTE_BITS-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (byte_done) begin
                     if (addr_hit && !shreg[0] && !conv_busy_i) phase <= PH_ADDR_ACK;
                     else                                       phase <= PH_SKIP;
                  end
               end
               PH_ADDR_ACK: begin
                  if (scl_fall) begin
                     phase  <= PH_DATA;
                     bitcnt <= '0;
                     armed  <= 1'b1;
                  end
               end
               PH_DATA: begin
                  if (scl_rise && bitcnt < LAST_BIT) begin
                     shreg  <= {shreg[BYTE_BITS-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (byte_done) begin
                     pend_rate <= shreg[RATE_BIT];
                     phase     <= PH_DATA_ACK;
                  end
               end
               PH_DATA_ACK: begin
                  if (scl_fall) begin
                     got_byte <= 1'b1;
                     phase    <= PH_SKIP;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign ack_drive_o   = (phase == PH_ADDR_ACK) || (phase == PH_DATA_ACK);
   assign commit_stb_o  = stb_q;
   assign commit_load_o = load_q;
   assign rate_new_o    = pend_rate;

   // R1: acknowledge drive only begins right after a clock falling edge
   assert_ack_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_drive_o) |-> $past(scl_fall));

   // R1: acknowledge release follows a falling edge or a bus condition
   assert_ack_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_drive_o) |-> $past(scl_fall || start_det || stop_det));

   // R3: an address acknowledge never follows a busy converter
   assert_no_ack_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ack_drive_o) && $past(phase) == PH_ADDR) |-> !$past(conv_busy_i));

endmodule

// File: rtl/cnv_cfg_commit.sv
module cnv_cfg_commit #(
   parameter bit RESET_RATE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic commit_stb_i,
   input  logic commit_load_i,
   input  logic rate_new_i,
   output logic rate_slow_o,
   output logic conv_start_o
);

   logic rate_q;
   logic start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q  <= RESET_RATE;
         start_q <= 1'b0;
      end else begin
         start_q <= commit_stb_i;
         if (commit_stb_i && commit_load_i) rate_q <= rate_new_i;
      end
   end

   assign rate_slow_o  = rate_q;
   assign conv_start_o = start_q;

   // R5: the rate only moves together with a start strobe
   assert_rate_with_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rate_q) |-> start_q);

   // R6: a commit without a data byte keeps the rate
   assert_abort_keeps_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && !$past(commit_load_i)) |-> $stable(rate_q));

endmodule

// File: rtl/cnv_ctl_i2c_target.sv
module cnv_ctl_i2c_target #(
   parameter logic [6:0] OWN_ADDR    = 7'b0010100,
   parameter logic [6:0] SYNC_ADDR   = 7'b1110111,
   parameter bit         GLOBAL_EN   = 1'b1,
   parameter int         SYNC_STAGES = 2,
   parameter int         RATE_BIT    = 0,
   parameter bit         RESET_RATE  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_drive_low_o,
   input  logic conv_busy_i,
   output logic conv_start_o,
   output logic rate_slow_o
);

   logic sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic commit_stb, commit_load, rate_new;

   cnv_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_raw   (scl_i),
      .sda_raw   (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   cnv_bus_engine #(
      .OWN_ADDR  (OWN_ADDR),
      .SYNC_ADDR (SYNC_ADDR),
      .GLOBAL_EN (GLOBAL_EN),
      .RATE_BIT  (RATE_BIT)
   ) u_engine (
      .clk           (clk),
      .rst_n         (rst_n),
      .sda_s         (sda_s),
      .scl_rise      (scl_rise),
      .scl_fall      (scl_fall),
      .start_det     (start_det),
      .stop_det      (stop_det),
      .conv_busy_i   (conv_busy_i),
      .ack_drive_o   (sda_drive_low_o),
      .commit_stb_o  (commit_stb),
      .commit_load_o (commit_load),
      .rate_new_o    (rate_new)
   );

   cnv_cfg_commit #(.RESET_RATE(RESET_RATE)) u_commit (
      .clk           (clk),
      .rst_n         (rst_n),
      .commit_stb_i  (commit_stb),
      .commit_load_i (commit_load),
      .rate_new_i    (rate_new),
      .rate_slow_o   (rate_slow_o),
      .conv_start_o  (conv_start_o)
   );

   // R9: strobe is a single clock wide
   assert_start_one_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |=> !conv_start_o);

   // R9: strobe trails a detected STOP by two clocks
   assert_start_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |-> $past(stop_det, 2));

endmodule

// File: tb/cnv_ctl_i2c_target_test.sv
`timescale 1ns/1ps
module cnv_ctl_i2c_target_test;

   localparam int Q        = 10;   // quarter bus period in system clocks
   localparam int CONV_CYC = 400;  // simulated conversion length
   localparam logic [6:0] OWN  = 7'b0010100;
   localparam logic [6:0] GLOB = 7'b1110111;

   // vector: addr[19:13] rw[12] has_data[11] data[10:3] exp_ack[2] exp_start[1] exp_rate[0]
   localparam int NV = 9;
   localparam logic [19:0] VEC [NV] = '{
      {OWN,          1'b0, 1'b1, 8'h01, 1'b1, 1'b1, 1'b1},  // R1 R4 R5
      {GLOB,         1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1},  // R2 R6
      {OWN,          1'b0, 1'b1, 8'hFE, 1'b1, 1'b1, 1'b0},  // R4 other bits ignored
      {7'b0010101,   1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0},  // R7 wrong address
      {OWN,          1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // R7 read
      {GLOB,         1'b0, 1'b1, 8'h03, 1'b1, 1'b1, 1'b1},  // R2 R5
      {OWN,          1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1},  // R6 abort keeps slow
      {GLOB,         1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1},  // R7 broadcast read
      {OWN,          1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0}   // R5
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_drive_low;
   logic conv_start;
   logic rate_slow;
   logic conv_busy;
   logic sda_line;

   int total = 0;
   int bad = 0;
   int starts = 0;
   int run = 0;
   int max_run = 0;
   int busy_timer = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   assign sda_line  = m_sda & ~sda_drive_low;
   assign conv_busy = (busy_timer != 0);

   cnv_ctl_i2c_target uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_i           (m_scl),
      .sda_i           (sda_line),
      .sda_drive_low_o (sda_drive_low),
      .conv_busy_i     (conv_busy),
      .conv_start_o    (conv_start),
      .rate_slow_o     (rate_slow)
   );

   // converter model and strobe monitor
   always @(posedge clk) begin
      if (conv_start) begin
         starts++;
         run++;
         if (run + 1 > max_run) max_run = run;
         busy_timer <= CONV_CYC;
      end else begin
         run = 0;
         if (busy_timer != 0) busy_timer <= busy_timer - 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_sda = 1'b1; wq(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; wq(Q);
         m_scl = 1'b1; wq(2*Q);
         m_scl = 1'b0; wq(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q);
      ack = sda_drive_low;
      wq(Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic wait_idle();
      while (conv_busy) @(negedge clk);
      wq(4);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit ack, ack2;
      int s0;
      logic r0;

      wq(5);
      // R10 reset state
      check(sda_drive_low == 1'b0, "R10 drive", sda_drive_low, 0);
      check(conv_start == 1'b0, "R10 start", conv_start, 0);
      check(rate_slow == 1'b0, "R10 rate", rate_slow, 0);
      rst_n = 1'b1;
      wq(10);

      // table walk
      for (int v = 0; v < NV; v++) begin
         wait_idle();
         s0 = starts;
         bus_start();
         send_byte({VEC[v][19:13], VEC[v][12]}, ack);
         check(ack == VEC[v][2], $sformatf("R1/R2/R7 addr ack v%0d", v), ack, VEC[v][2]);
         if (VEC[v][11]) begin
            send_byte(VEC[v][10:3], ack2);
            check(ack2 == VEC[v][2], $sformatf("R4 data ack v%0d", v), ack2, VEC[v][2]);
         end
         bus_stop();
         wq(4);
         check((starts - s0) == int'(VEC[v][1]), $sformatf("R5/R6/R7 start count v%0d", v),
               starts - s0, VEC[v][1]);
         check(rate_slow == VEC[v][0], $sformatf("R4/R5/R6 rate v%0d", v), rate_slow, VEC[v][0]);
         check(sda_drive_low == 1'b0, $sformatf("R1 released v%0d", v), sda_drive_low, 0);
      end

      // R3: converter busy right after a restart -> no ack, no strobe
      wait_idle();
      r0 = rate_slow;
      bus_start();
      send_byte({OWN, 1'b0}, ack);
      bus_stop();
      wq(4);
      check(conv_busy == 1'b1, "R3 setup busy", conv_busy, 1);
      s0 = starts;
      bus_start();
      send_byte({OWN, 1'b0}, ack);
      check(ack == 1'b0, "R3 busy addr ack", ack, 0);
      send_byte(8'h01, ack2);
      check(ack2 == 1'b0, "R3 busy data ack", ack2, 0);
      bus_stop();
      wq(4);
      check(starts == s0, "R3 no start", starts - s0, 0);
      check(rate_slow == r0, "R3 rate kept", rate_slow, r0);

      // R8: repeated START after three address bits, then a valid write
      wait_idle();
      s0 = starts;
      bus_start();
      send_bits({GLOB, 1'b1}, 3);
      bus_start();
      send_byte({OWN, 1'b0}, ack);
      check(ack == 1'b1, "R8 addr ack after restart", ack, 1);
      send_byte(8'h01, ack2);
      check(ack2 == 1'b1, "R8 data ack", ack2, 1);
      bus_stop();
      wq(4);
      check((starts - s0) == 1, "R8 start", starts - s0, 1);
      check(rate_slow == 1'b1, "R8 rate", rate_slow, 1);

      // R11: second data byte not acknowledged, first byte committed
      wait_idle();
      s0 = starts;
      bus_start();
      send_byte({GLOB, 1'b0}, ack);
      send_byte(8'h00, ack);
      check(ack == 1'b1, "R11 first byte ack", ack, 1);
      send_byte(8'h01, ack2);
      check(ack2 == 1'b0, "R11 extra byte nack", ack2, 0);
      bus_stop();
      wq(4);
      check((starts - s0) == 1, "R11 start", starts - s0, 1);
      check(rate_slow == 1'b0, "R11 rate from first byte", rate_slow, 0);

      // R9: every strobe was exactly one clock wide
      check(max_run == 1, "R9 strobe width", max_run, 1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule